// File: doc/BRIEF.md
# Serial Per-Channel Tristate Control Encoder

This block tells a set of external output buffers, one channel at a time, whether each of sixteen 32.768 Mb/s data streams should drive its pin or float. It runs from a 16.384 MHz clock and puts one control bit on each of four serial lines per clock period. Each line serves four streams: line `k` carries streams `k`, `k+4`, `k+8` and `k+12`. Within each channel the four streams are interleaved in that ascending order. A frame is 2048 clock periods long and holds 512 channels per stream.

The block reads the per-channel output-enable bits through a synchronous lookup port. Each cycle it presents a group index and a channel number. One cycle later it takes back four bits, one for each line. A free-running period counter is aligned by a frame pulse. The counter runs two periods ahead of the serial lines, so each read result is registered onto the lines in the period it belongs to. The whole bit sequence is placed five periods early, so the bit for channel 0 of the first stream of a line goes out six periods before the frame boundary. This gives the external buffers time to switch before their channel starts.

Top module: `tristate_ctl_encoder`

## Requirements
- R1: After reset and until the first frame pulse, all four control lines, `rd_en_o` and `misalign_o` are low.
- R2: Bit `k` of `en_bits_i` is the enable of stream `k + 4*rd_grp_o` at channel `rd_chan_o`, and that bit goes out unchanged on `ctl_o[k]`. A low value means that stream's channel must float.
- R3: With the period number P in the range 1..2048 and t = (P + 5) mod 2048, period P carries channel t/4 of group t mod 4. Examples: stream 0 channel 0 is sent in period 2043, stream 12 channel 0 in period 2046, stream 4 channel 510 in period 2036, and stream 5 channel 4 in period 12.
- R4: When `frame_i` is sampled high at a clock edge, the clock period that starts at that edge is period 1.
- R5: The lookup is synchronous with one cycle of latency. `rd_en_o` is high from the first frame pulse onward, and the address presented in a cycle is the one for the period two cycles later.
- R6: After the first frame pulse, or after a frame pulse at an unexpected count, the lines are low in periods 1 and 2. Normal output resumes in period 3.
- R7: A frame pulse that arrives exactly 2048 cycles after the previous period 1 causes no gap or change in the output.
- R8: `misalign_o` goes high in the cycle after a frame pulse that is not exactly on the frame boundary, and it stays high until reset. The first pulse after reset never sets it.
- R9: Once aligned, the frame keeps running with a period of 2048 cycles when frame pulses are missing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 16.384 MHz bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Frame pulse; the period starting at the edge that samples it high is period 1 |
| rd_en_o | output | 1 | Enable-bit lookup request |
| rd_grp_o | output | 2 | Stream group being read (selects streams k + 4*group) |
| rd_chan_o | output | 9 | Channel number being read |
| en_bits_i | input | 4 | Enable bits returned one cycle after the request, bit k for line k |
| ctl_o | output | 4 | Serial control lines, one bit per clock period |
| misalign_o | output | 1 | Sticky flag for a frame pulse at an unexpected count |

## Verification
Two registers lie between a frame pulse and the line data: the lookup register in the bench's memory model and the line register. The first period after the edge that samples the pulse is therefore period 1, and that period's address was issued two cycles before its data appears. The misalignment flag changes in the cycle that starts at the sampling edge. The bench drives every input at the falling edge and samples every output at the next falling edge. It tracks its own period count, restarting at the pulse edge, and from R3 it predicts the value of every line in every period across whole frames. Enable patterns are changed only together with a realigning pulse, so the two blanked periods cover the lookup that is still in flight.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    // Lookahead between the period counter and the serial lines:
    // one cycle for the synchronous lookup, one for the line register.
    localparam int unsigned PIPE_DEPTH = 2;

    typedef enum logic {
        SYNC_IDLE   = 1'b0,
        SYNC_LOCKED = 1'b1
    } sync_e;

endpackage

// File: rtl/tsc_frame_timer.sv
module tsc_frame_timer
    import tsc_pkg::*;
#(
    parameter int unsigned PERIODS = 2048,
    localparam int unsigned CW     = $clog2(PERIODS)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          frame_i,
    output logic [CW-1:0] cnt_o,
    output logic          locked_o,
    output logic          resync_o,
    output logic          misalign_o
);

    localparam logic [CW-1:0] START_CNT = CW'(PIPE_DEPTH);
    localparam logic [CW-1:0] EXP_CNT   = CW'(PIPE_DEPTH - 1);
    localparam logic [CW-1:0] LAST_CNT  = CW'(PERIODS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        sync_e         st;
        logic          mis;
    } timer_s;

    timer_s s_d, s_q;
    logic   on_time;

    always_comb begin
        s_d     = s_q;
        on_time = (s_q.st == SYNC_LOCKED) && (s_q.cnt == EXP_CNT);

        if (frame_i) begin
            s_d.cnt = START_CNT;
            s_d.st  = SYNC_LOCKED;
        end else if (s_q.cnt == LAST_CNT) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end

        if (frame_i && (s_q.st == SYNC_LOCKED) && !on_time) begin
            s_d.mis = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{cnt: '0, st: SYNC_IDLE, mis: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o      = s_q.cnt;
    assign locked_o   = (s_q.st == SYNC_LOCKED);
    assign resync_o   = frame_i && !on_time;
    assign misalign_o = s_q.mis;

    // R4
    fp_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_i |=> (s_q.cnt == START_CNT) && (s_q.st == SYNC_LOCKED));

    // R9
    free_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_i |=> (($past(s_q.cnt) == LAST_CNT) ? (s_q.cnt == '0)
                                                    : (s_q.cnt == $past(s_q.cnt) + 1'b1)));

    // R8
    mis_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.mis |=> s_q.mis);

    // R8
    first_fp_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_i && (s_q.st == SYNC_IDLE) && !s_q.mis) |=> !s_q.mis);

endmodule

// File: rtl/tsc_addr_map.sv
module tsc_addr_map #(
    parameter int unsigned CHANNELS = 512,
    parameter int unsigned GROUPS   = 4,
    parameter int unsigned LEAD     = 5,
    localparam int unsigned PERIODS = CHANNELS * GROUPS,
    localparam int unsigned CW      = $clog2(PERIODS),
    localparam int unsigned SW      = $clog2(GROUPS),
    localparam int unsigned NW      = $clog2(CHANNELS)
) (
    input  logic [CW-1:0] cnt_i,
    output logic [SW-1:0] grp_o,
    output logic [NW-1:0] chan_o
);

    localparam int unsigned TW = CW + 1;

    logic [TW-1:0] slot_pos;

    // Counter index i is period i+1; the sequence runs LEAD periods early.
    always_comb begin
        slot_pos = {1'b0, cnt_i} + TW'(LEAD + 1);
        if (slot_pos >= TW'(PERIODS)) begin
            slot_pos = slot_pos - TW'(PERIODS);
        end
        grp_o  = SW'(slot_pos % TW'(GROUPS));
        chan_o = NW'(slot_pos / TW'(GROUPS));
    end

endmodule

// File: rtl/tsc_serializer.sv
module tsc_serializer #(
    parameter int unsigned LINES = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             locked_i,
    input  logic             resync_i,
    input  logic [LINES-1:0] en_bits_i,
    output logic [LINES-1:0] ctl_o
);

    typedef struct packed {
        logic             dv;
        logic [LINES-1:0] line;
    } ser_s;

    ser_s             s_d, s_q;
    logic             pass;
    logic [LINES-1:0] gated;

    assign pass = s_q.dv && !resync_i;

    for (genvar k = 0; k < LINES; k++) begin : g_gate
        assign gated[k] = en_bits_i[k] & pass;
    end

    always_comb begin
        s_d      = s_q;
        s_d.dv   = locked_i && !resync_i;
        s_d.line = gated;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_o = s_q.line;

    // R1
    idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !locked_i |=> (ctl_o == '0));

    // R6
    resync_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resync_i |=> (ctl_o == '0) ##1 (ctl_o == '0));

endmodule

// File: rtl/tristate_ctl_encoder.sv
module tristate_ctl_encoder
    import tsc_pkg::*;
#(
    parameter int unsigned CHANNELS = 512,
    parameter int unsigned GROUPS   = 4,
    parameter int unsigned LINES    = 4,
    parameter int unsigned LEAD     = 5,
    localparam int unsigned PERIODS = CHANNELS * GROUPS,
    localparam int unsigned CW      = $clog2(PERIODS),
    localparam int unsigned SW      = $clog2(GROUPS),
    localparam int unsigned NW      = $clog2(CHANNELS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             frame_i,
    output logic             rd_en_o,
    output logic [SW-1:0]    rd_grp_o,
    output logic [NW-1:0]    rd_chan_o,
    input  logic [LINES-1:0] en_bits_i,
    output logic [LINES-1:0] ctl_o,
    output logic             misalign_o
);

    logic [CW-1:0] cnt;
    logic          locked;
    logic          resync;

    tsc_frame_timer #(
        .PERIODS (PERIODS)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .frame_i    (frame_i),
        .cnt_o      (cnt),
        .locked_o   (locked),
        .resync_o   (resync),
        .misalign_o (misalign_o)
    );

    tsc_addr_map #(
        .CHANNELS (CHANNELS),
        .GROUPS   (GROUPS),
        .LEAD     (LEAD)
    ) u_map (
        .cnt_i  (cnt),
        .grp_o  (rd_grp_o),
        .chan_o (rd_chan_o)
    );

    tsc_serializer #(
        .LINES (LINES)
    ) u_ser (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .locked_i  (locked),
        .resync_i  (resync),
        .en_bits_i (en_bits_i),
        .ctl_o     (ctl_o)
    );

    assign rd_en_o = locked;

    // R3
    grp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_i |=> (rd_grp_o == SW'($past(rd_grp_o) + SW'(1))));

    // R5
    rd_en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_o || frame_i) |=> rd_en_o);

endmodule

// File: tb/sim_tristate_ctl_encoder.sv
module sim_tristate_ctl_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int NPER       = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame = 1'b0;
    logic       rd_en;
    logic [1:0] rd_grp;
    logic [8:0] rd_chan;
    logic [3:0] en_bits = '0;
    logic [3:0] ctl;
    logic       mis;

    int n_checks = 0;
    int n_fail   = 0;

    // pattern control
    int mode   = 0;
    int sel_s  = 0;
    int sel_ch = 0;

    // bench model of the alignment state
    bit synced = 0;
    bit exp_mis = 0;
    int j = 0;         // cycles since last period 1
    int blank = 0;     // periods still to be blanked
    int hits = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tristate_ctl_encoder u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .frame_i    (frame),
        .rd_en_o    (rd_en),
        .rd_grp_o   (rd_grp),
        .rd_chan_o  (rd_chan),
        .en_bits_i  (en_bits),
        .ctl_o      (ctl),
        .misalign_o (mis)
    );

    function automatic logic enf(int s, int ch);
        case (mode)
            0:       return ((s * 13 + ch * 7) % 3) == 0;
            1:       return ((s * 5 + ch * 3 + ch / 7) % 4) != 0;
            default: return (s == sel_s) && (ch == sel_ch);
        endcase
    endfunction

    // enable memory with one cycle of read latency (R2, R5)
    always @(posedge clk) begin
        if (rd_en) begin
            for (int k = 0; k < 4; k++) begin
                en_bits[k] <= enf(k + 4 * rd_grp, rd_chan);
            end
        end
    end

    // R3 expectation for period P (1..2048)
    function automatic logic [3:0] exp_line(int p);
        int t;
        logic [3:0] v;
        t = (p + 5) % NPER;
        for (int k = 0; k < 4; k++) v[k] = enf(k + 4 * (t % 4), t / 4);
        return v;
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s period %0d: got {mis,rd_en,ctl}=%b expected %b",
                     req, (j % NPER) + 1, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, sample at the next falling edge.
    task automatic step(input bit fp);
        logic [3:0] e;
        string req;
        frame = fp;
        @(posedge clk);
        if (fp) begin
            if (synced && (j % NPER) == NPER - 1) begin
                j = 0;                       // R7 aligned pulse, no gap
            end else begin
                if (synced) exp_mis = 1;     // R8
                synced = 1;
                j = 0;
                blank = 2;                   // R6
            end
        end else if (synced) begin
            j++;                             // R9 keeps running
        end
        @(negedge clk);
        frame = 1'b0;
        if (!synced) begin
            e = '0; req = "R1";
        end else if (blank > 0) begin
            e = '0; req = "R6"; blank--;
        end else begin
            e = exp_line((j % NPER) + 1); req = "R3";
        end
        check(req, {mis, rd_en, ctl}, {exp_mis, synced, e});
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    // Frame with one enabled channel: the line must be high in exactly one period.
    task automatic single(input int s, input int ch, input int per, input int skew);
        run(skew);
        mode = 2; sel_s = s; sel_ch = ch;
        step(1'b1);
        hits = 0;
        for (int i = 1; i < NPER; i++) begin
            step(1'b0);
            if (ctl[s % 4]) begin
                hits++;
                n_checks++;
                if ((j % NPER) + 1 != per) begin
                    n_fail++;
                    $display("FAIL R3 stream %0d ch %0d: high in period %0d expected %0d",
                             s, ch, (j % NPER) + 1, per);
                end
            end
        end
        n_checks++;
        if (hits != 1) begin
            n_fail++;
            $display("FAIL R2 stream %0d ch %0d: %0d high periods expected 1", s, ch, hits);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet before the first pulse
        run(20);
        // R4, R2, R3: first pulse, then a full aligned frame
        mode = 0;
        step(1'b1);
        run(NPER - 1);
        // R7: pulse exactly on the boundary
        step(1'b1);
        run(NPER - 1);
        // R9: boundary without a pulse
        run(NPER);
        // R8, R6: early pulse with a new pattern
        run(300);
        mode = 1;
        step(1'b1);
        run(NPER + 10);
        // R3 worked examples, each realigned at an off-boundary count
        single(0, 0, 2043, 17);
        single(12, 0, 2046, 5);
        single(4, 510, 2036, 9);
        single(5, 4, 12, 3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule